// File: doc/BRIEF.md
# LCD Frame Clock and Blink Generator

This block turns a slow LCD kernel clock into the timing events a segment LCD controller needs. The kernel clock arrives as a one-cycle enable, `kern_en`, in the system clock domain. A power-of-two prescaler counts these enables and emits a prescaled tick. A second counter divides that tick by sixteen plus a programmable amount to produce the frame (phase) tick. A blink timer counts frame ticks and inverts a blink phase bit at a programmable power-of-two fraction of the frame rate.

From the blink phase and a scope selector, the block drives pixel blink masks. The scope can be one pixel (segment 0 on common 0), segment 0 across every common, or the whole panel. Every output is a registered signal in the system clock domain. No derived clocks are produced.

All settings come from a 32-bit control word. Changes to the rate fields are picked up only when the counter they govern wraps, so a tick period is never cut short.

Top module: `lcd_frame_timer`

## Requirements
- R1: With prescale select `p` in control bits 25:22, `pre_tick` rises once every 2^p `kern_en` pulses. With `kern_en` high every cycle this gives a spacing of 2^p clocks (p = 0 gives 1, p = 15 gives 32768).
- R2: With divide add `d` in control bits 21:18, `frame_tick` rises once every 16 + d `pre_tick` pulses. With `kern_en` high every cycle the spacing is 2^p·(16 + d) clocks.
- R3: With blink rate `r` in control bits 15:13, `blink_phase` inverts once every 2^(3+r) frame ticks.
- R4: With blink scope 0 in control bits 17:16, the masks stay all zero whatever the blink phase.
- R5: With scope 1, while the phase is 1, `blink_com_mask` is 1 on common 0 only, `blink_seg0` is 1 and `blink_seg_all` is 0. While the phase is 0, all masks are 0.
- R6: With scope 2, while the phase is 1, every bit of `blink_com_mask` is 1, `blink_seg0` is 1 and `blink_seg_all` is 0.
- R7: With scope 3, while the phase is 1, every bit of `blink_com_mask` is 1 and both `blink_seg0` and `blink_seg_all` are 1.
- R8: A new prescale, divide or blink rate value takes effect only at the next wrap of its counter. The period already running completes with the old value.
- R9: While `rst_n` is low, all outputs are 0. After release, every counter starts from zero with a select of 0.
- R10: `pre_tick` is high only in the cycle after a `kern_en` pulse. `frame_tick` is never high in two consecutive cycles. With sparse enables, each tick lasts one cycle.
- R11: The masks follow the blink phase with one clock of delay. In the first cycle that `blink_phase` reads 1, the masks still show 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kern_en | input | 1 | One-cycle enable per LCD kernel clock period |
| ctrl_word | input | 32 | Control word carrying prescale, divide, blink scope and blink rate fields |
| pre_tick | output | 1 | Prescaled tick |
| frame_tick | output | 1 | Frame/phase tick |
| blink_phase | output | 1 | Current blink phase, 1 = blinked pixels off |
| blink_seg0 | output | 1 | Segment 0 is in the blink set this cycle |
| blink_seg_all | output | 1 | Every segment is in the blink set this cycle |
| blink_com_mask | output | NUM_COM | Commons in the blink set this cycle |

## Verification
The assertions guard properties that must hold on every cycle:
- a prescaled tick only ever follows an enable;
- a frame tick only ever follows a prescaled tick and is never doubled;
- each counter stays within its limit;
- the blink phase moves only on a blink-counter wrap;
- the masks appear only a cycle after the phase was 1 and keep to their scope nesting.

Tick spacings for the prescale and divide settings, the blink rate, the exact mask pattern per scope, and the deferral of a live setting change to the next wrap are quantitative. Only the bench's directed scenarios can show them, by measuring intervals and sampling the masks at known phases.

// File: rtl/lft_pkg.sv
package lft_pkg;
   // control word field placement
   localparam int PRE_LSB    = 22;
   localparam int PRE_W      = 4;
   localparam int DADD_LSB   = 18;
   localparam int DADD_W     = 4;
   localparam int SCOPE_LSB  = 16;
   localparam int SCOPE_W    = 2;
   localparam int BRATE_LSB  = 13;
   localparam int BRATE_W    = 3;
   // fixed divider offset and blink base exponent
   localparam int DIV_OFFSET = 16;
   localparam int BLINK_BASE = 3;

   typedef enum logic [1:0] {
      SCOPE_OFF      = 2'd0,
      SCOPE_PIXEL    = 2'd1,
      SCOPE_SEG0_COL = 2'd2,
      SCOPE_PANEL    = 2'd3
   } blink_scope_e;
endpackage

// File: rtl/lft_pow2_counter.sv
// Counts step pulses and emits a registered tick every 2^(BASE_SHIFT+sel) steps.
// The select is sampled only when the count wraps.
module lft_pow2_counter #(
   parameter int SEL_W      = 4,
   parameter int BASE_SHIFT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [SEL_W-1:0] sel_in,
   output logic             tick_o
);
   localparam int CNT_W = BASE_SHIFT + (1 << SEL_W) - 1;
   localparam logic [CNT_W:0] ONE = 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("lft_pow2_counter: SEL_W out of range");
   end
   if (BASE_SHIFT < 0 || BASE_SHIFT > 8) begin : g_bad_base
      $error("lft_pow2_counter: BASE_SHIFT out of range");
   end

   logic [SEL_W-1:0] sel_act;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic [CNT_W:0]   span;
   logic             at_end;

   always_comb begin
      span  = ONE << (BASE_SHIFT + int'(sel_act));
      limit = span[CNT_W-1:0] - ONE[CNT_W-1:0];
   end

   assign at_end = (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         sel_act <= '0;
         tick_o  <= 1'b0;
      end else begin
         tick_o <= step_en && at_end;
         if (step_en) begin
            if (at_end) begin
               cnt     <= '0;
               sel_act <= sel_in;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   assert_tick_after_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(step_en));
   assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);
endmodule

// File: rtl/lft_frame_div.sv
// Divides the prescaled tick by OFFSET plus a programmable addend.
module lft_frame_div #(
   parameter int ADD_W  = 4,
   parameter int OFFSET = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [ADD_W-1:0] add_in,
   output logic             tick_o
);
   localparam int CW = $clog2(OFFSET + (1 << ADD_W));

   if (OFFSET < 2) begin : g_bad_off
      $error("lft_frame_div: OFFSET must be at least 2");
   end

   logic [ADD_W-1:0] add_act;
   logic [CW-1:0]    cnt;
   logic [CW-1:0]    limit;

   assign limit = CW'(OFFSET - 1) + CW'(add_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         add_act <= '0;
         tick_o  <= 1'b0;
      end else begin
         tick_o <= step_en && (cnt == limit);
         if (step_en) begin
            if (cnt == limit) begin
               cnt     <= '0;
               add_act <= add_in;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assert_frame_after_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(step_en));
   assert_frame_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
   assert_div_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);
endmodule

// File: rtl/lft_blink.sv
// Blink phase timer and pixel scope masks.
module lft_blink
   import lft_pkg::*;
#(
   parameter int RATE_W     = 3,
   parameter int BASE_SHIFT = 3,
   parameter int NUM_COM    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic [RATE_W-1:0] rate_in,
   input  blink_scope_e      scope_in,
   output logic              phase_o,
   output logic              seg0_o,
   output logic              seg_all_o,
   output logic [NUM_COM-1:0] com_o
);
   logic               wrap_tick;
   logic [NUM_COM-1:0] com_hit;

   lft_pow2_counter #(.SEL_W(RATE_W), .BASE_SHIFT(BASE_SHIFT)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (frame_tick),
      .sel_in  (rate_in),
      .tick_o  (wrap_tick)
   );

   for (genvar k = 0; k < NUM_COM; k++) begin : g_com
      assign com_hit[k] = (scope_in == SCOPE_PANEL) || (scope_in == SCOPE_SEG0_COL) ||
                          ((scope_in == SCOPE_PIXEL) && (k == 0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o   <= 1'b0;
         seg0_o    <= 1'b0;
         seg_all_o <= 1'b0;
         com_o     <= '0;
      end else begin
         if (wrap_tick) phase_o <= ~phase_o;
         seg0_o    <= phase_o && (scope_in != SCOPE_OFF);
         seg_all_o <= phase_o && (scope_in == SCOPE_PANEL);
         com_o     <= phase_o ? com_hit : '0;
      end
   end

   assert_phase_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o != $past(phase_o)) |-> $past(wrap_tick));
   assert_mask_lags_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((|com_o) || seg0_o) |-> $past(phase_o));
   assert_panel_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seg_all_o |-> ((&com_o) && seg0_o));
   assert_seg0_has_com_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seg0_o |-> com_o[0]);
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
   import lft_pkg::*;
#(
   parameter int NUM_COM = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kern_en,
   input  logic [31:0]        ctrl_word,
   output logic               pre_tick,
   output logic               frame_tick,
   output logic               blink_phase,
   output logic               blink_seg0,
   output logic               blink_seg_all,
   output logic [NUM_COM-1:0] blink_com_mask
);
   if (NUM_COM < 1 || NUM_COM > 8) begin : g_bad_com
      $error("lcd_frame_timer: NUM_COM must be 1..8");
   end

   logic ctrl_unused;
   assign ctrl_unused = ^{ctrl_word[31:26], ctrl_word[12:0]};

   lft_pow2_counter #(.SEL_W(PRE_W), .BASE_SHIFT(0)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (kern_en),
      .sel_in  (ctrl_word[PRE_LSB +: PRE_W]),
      .tick_o  (pre_tick)
   );

   lft_frame_div #(.ADD_W(DADD_W), .OFFSET(DIV_OFFSET)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (pre_tick),
      .add_in  (ctrl_word[DADD_LSB +: DADD_W]),
      .tick_o  (frame_tick)
   );

   lft_blink #(.RATE_W(BRATE_W), .BASE_SHIFT(BLINK_BASE), .NUM_COM(NUM_COM)) u_blink (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .rate_in    (ctrl_word[BRATE_LSB +: BRATE_W]),
      .scope_in   (blink_scope_e'(ctrl_word[SCOPE_LSB +: SCOPE_W])),
      .phase_o    (blink_phase),
      .seg0_o     (blink_seg0),
      .seg_all_o  (blink_seg_all),
      .com_o      (blink_com_mask)
   );
endmodule

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_COM    = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               kern_en = 1'b0;
   logic [31:0]        ctrl_word = '0;
   logic               pre_tick, frame_tick, blink_phase, blink_seg0, blink_seg_all;
   logic [NUM_COM-1:0] blink_com_mask;

   int n_checks = 0;
   int n_errors = 0;
   int kgap = 1;
   int kcount = 0;

   lcd_frame_timer #(.NUM_COM(NUM_COM)) u_lcd_frame_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .kern_en        (kern_en),
      .ctrl_word      (ctrl_word),
      .pre_tick       (pre_tick),
      .frame_tick     (frame_tick),
      .blink_phase    (blink_phase),
      .blink_seg0     (blink_seg0),
      .blink_seg_all  (blink_seg_all),
      .blink_com_mask (blink_com_mask)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // kernel enable: one pulse every kgap clocks
   initial forever begin
      @(negedge clk);
      kcount++;
      if (kcount >= kgap) begin
         kcount  = 0;
         kern_en = 1'b1;
      end else begin
         kern_en = 1'b0;
      end
   end

   function automatic logic [31:0] mk(int pre, int dadd, int scope, int rate);
      return (32'(pre) << 22) | (32'(dadd) << 18) | (32'(scope) << 16) | (32'(rate) << 13);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic restart();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic sig(int w);
      return (w == 0) ? pre_tick : frame_tick;
   endfunction

   task automatic next_gap(int w, output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!sig(w));
   endtask

   task automatic gap(int w, output int g);
      while (!sig(w)) @(negedge clk);
      next_gap(w, g);
   endtask

   task automatic phase_gap(output int g);
      logic p;
      p = blink_phase;
      while (blink_phase == p) @(negedge clk);
      p = blink_phase;
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (blink_phase == p);
   endtask

   task automatic test_reset();
      kgap = 1;
      ctrl_word = mk(0, 0, 3, 0);
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      check(pre_tick == 0, "R9 pre_tick in reset", int'(pre_tick), 0);
      check(frame_tick == 0, "R9 frame_tick in reset", int'(frame_tick), 0);
      check(blink_phase == 0, "R9 blink_phase in reset", int'(blink_phase), 0);
      check(blink_seg0 == 0, "R9 blink_seg0 in reset", int'(blink_seg0), 0);
      check(blink_seg_all == 0, "R9 blink_seg_all in reset", int'(blink_seg_all), 0);
      check(blink_com_mask == 0, "R9 com mask in reset", int'(blink_com_mask), 0);
   endtask

   task automatic test_prescale();
      int g;
      int sels[3] = '{0, 1, 15};
      kgap = 1;
      foreach (sels[i]) begin
         ctrl_word = mk(sels[i], 0, 0, 0);
         restart();
         gap(0, g);
         check(g == (1 << sels[i]), "R1 prescale spacing", g, 1 << sels[i]);
      end
   endtask

   task automatic test_divide();
      int g;
      int exp;
      kgap = 1;
      for (int p = 0; p < 2; p++) begin
         for (int d = 0; d < 16; d += 15) begin
            ctrl_word = mk(p, d, 0, 0);
            restart();
            gap(1, g);
            next_gap(1, g);
            exp = (1 << p) * (16 + d);
            check(g == exp, "R2 frame spacing", g, exp);
         end
      end
   endtask

   task automatic test_enable_rate();
      int g;
      kgap = 3;
      ctrl_word = mk(0, 0, 0, 0);
      restart();
      gap(0, g);
      next_gap(0, g);
      check(g == 3, "R1 sparse enable spacing", g, 3);
      @(negedge clk);
      check(pre_tick == 0, "R10 pre_tick single cycle", int'(pre_tick), 0);
      ctrl_word = mk(2, 0, 0, 0);
      restart();
      gap(0, g);
      next_gap(0, g);
      check(g == 12, "R1 sparse enable with prescale 2", g, 12);
      gap(1, g);
      @(negedge clk);
      check(frame_tick == 0, "R10 frame_tick single cycle", int'(frame_tick), 0);
      kgap = 1;
   endtask

   task automatic test_live_change();
      int g;
      kgap = 1;
      ctrl_word = mk(3, 0, 0, 0);
      restart();
      gap(0, g);
      ctrl_word = mk(1, 0, 0, 0);
      next_gap(0, g);
      check(g == 8, "R8 old prescale finishes period", g, 8);
      next_gap(0, g);
      check(g == 2, "R8 new prescale after wrap", g, 2);
   endtask

   task automatic test_blink_rate();
      int g;
      kgap = 1;
      ctrl_word = mk(0, 0, 0, 0);
      restart();
      phase_gap(g);
      check(g == 128, "R3 blink rate 0", g, 128);
      ctrl_word = mk(0, 0, 0, 2);
      restart();
      phase_gap(g);
      check(g == 512, "R3 blink rate 2", g, 512);
   endtask

   task automatic test_masks();
      int exp_com;
      kgap = 1;
      ctrl_word = mk(0, 0, 0, 0);
      restart();
      for (int s = 0; s < 4; s++) begin
         ctrl_word = mk(0, 0, s, 0);
         while (blink_phase != 1'b0) @(negedge clk);
         while (blink_phase != 1'b1) @(negedge clk);
         if (s == 3)
            check(blink_seg_all == 0, "R11 mask lags phase", int'(blink_seg_all), 0);
         @(negedge clk);
         exp_com = (s == 0) ? 0 : ((s == 1) ? 1 : 255);
         case (s)
            0: begin
               check(blink_com_mask == 0, "R4 scope off com mask", int'(blink_com_mask), 0);
               check(blink_seg0 == 0, "R4 scope off seg0", int'(blink_seg0), 0);
               check(blink_seg_all == 0, "R4 scope off seg_all", int'(blink_seg_all), 0);
            end
            1: begin
               check(int'(blink_com_mask) == exp_com, "R5 pixel com mask", int'(blink_com_mask), exp_com);
               check(blink_seg0 == 1, "R5 pixel seg0", int'(blink_seg0), 1);
               check(blink_seg_all == 0, "R5 pixel seg_all", int'(blink_seg_all), 0);
            end
            2: begin
               check(int'(blink_com_mask) == exp_com, "R6 column com mask", int'(blink_com_mask), exp_com);
               check(blink_seg0 == 1, "R6 column seg0", int'(blink_seg0), 1);
               check(blink_seg_all == 0, "R6 column seg_all", int'(blink_seg_all), 0);
            end
            default: begin
               check(int'(blink_com_mask) == exp_com, "R7 panel com mask", int'(blink_com_mask), exp_com);
               check(blink_seg0 == 1, "R7 panel seg0", int'(blink_seg0), 1);
               check(blink_seg_all == 1, "R7 panel seg_all", int'(blink_seg_all), 1);
            end
         endcase
         if (s == 1) begin
            while (blink_phase != 1'b0) @(negedge clk);
            repeat (2) @(negedge clk);
            check(blink_com_mask == 0, "R5 phase 0 clears com mask", int'(blink_com_mask), 0);
            check(blink_seg0 == 0, "R5 phase 0 clears seg0", int'(blink_seg0), 0);
         end
      end
   endtask

   initial begin
      test_reset();
      test_prescale();
      test_divide();
      test_enable_rate();
      test_live_change();
      test_blink_rate();
      test_masks();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 195000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule